// File: doc/BRIEF.md
# Supply Undervoltage Supervisor with Timed Recovery

This block watches four supply-good flags of a power-stage controller: the motor supply, the input of the on-chip regulator, the output of that regulator and the charge pump. It decides when the power outputs and the charge pump may run, when the rest of the device is held in reset, and when the open-drain fault pin is pulled low. It also keeps sticky status bits that record what went wrong.

The two regulator flags behave differently from the other two. A bad regulator rail holds the device in reset, and the reset lets go as soon as the rail is good again. A bad motor-supply or charge-pump rail stops the outputs and the charge pump and pulls the fault pin low. Recovery from that fault waits for a retry delay, and the delay only starts counting once the rail is back above its threshold. A 2-bit mode picks a slow or a fast delay. Both delays are parameters in clock cycles. The status bits stay set after recovery until software writes a clear strobe, or until the sleep pin gives a low pulse that lasts long enough. Rail flags arrive already synchronized and hysteretic.

Top module: `uv_supervisor`

## Requirements
- R1: No input or mode value disables supervision. With retryMode = 2'b11, a motor-supply drop still stops the outputs and sets the status bits.
- R2: When vinRegGood or regOutGood is low at a clock edge, coreReset is 1 after that edge and outEnable and cpEnable are 0.
- R3: When both regulator flags are high again at an edge, coreReset is 0 after that edge and outEnable returns with no retry delay. A regulator fault sets no status bit and does not drive faultPinLow.
- R4: When vmGood or cpGood is low at an edge, after that edge outEnable = 0, cpEnable = 0 and faultPinLow = 1.
- R5: That same edge sets stsFault and stsUvp. It also sets stsVmUv if vmGood was low, and stsCpUv if cpGood was low.
- R6: Let E0 be the first edge at which both vmGood and cpGood are high after such a fault. outEnable and cpEnable return to 1, and faultPinLow returns to 0, exactly LIMIT edges after E0. They stay off before that.
- R7: LIMIT is SLOW_CYC when retryMode = 2'b00 and FAST_CYC for any other value.
- R8: If vmGood or cpGood drops during the retry count, the count is abandoned. A full LIMIT is counted again from the next edge at which both rails are good.
- R9: The status bits remain 1 after the automatic recovery. A one-cycle faultClr clears all four of them at the next edge.
- R10: A clear request, whether from faultClr or from the sleep pin, is ignored while vmGood or cpGood is low, and the status bits stay 1.
- R11: The sleep pin acts as a clear when sleepN was low for at least SLEEP_MIN consecutive edges and is then seen high. A shorter low pulse clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vmGood | input | 1 | Motor supply above threshold |
| vinRegGood | input | 1 | Regulator input above threshold |
| regOutGood | input | 1 | Regulator output above threshold |
| cpGood | input | 1 | Charge pump above threshold |
| retryMode | input | 2 | 00 selects the slow retry, any other value the fast retry |
| faultClr | input | 1 | Clear strobe for the status bits |
| sleepN | input | 1 | Sleep pin; a qualified low pulse acts as a clear |
| outEnable | output | 1 | Power outputs may switch (0 = high impedance) |
| cpEnable | output | 1 | Charge pump enable |
| coreReset | output | 1 | Holds the device core in reset |
| faultPinLow | output | 1 | Drives the open-drain fault pin low |
| stsFault | output | 1 | Sticky general fault bit |
| stsUvp | output | 1 | Sticky undervoltage bit |
| stsVmUv | output | 1 | Sticky motor-supply undervoltage bit |
| stsCpUv | output | 1 | Sticky charge-pump undervoltage bit |

## Verification
The assertions assume that every rail flag is already synchronous to clk and free of chatter, so a single low sample counts as a real fault. They also assume SLOW_CYC is at least FAST_CYC, which bounds the retry counter. The bench changes every input half a period away from the rising edge and holds each flag level for whole cycles. It keeps SLOW_CYC above FAST_CYC, and it changes retryMode only while no retry count is running.

// File: rtl/uvsup_pkg.sv
package uvsup_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DOWN  = 2'd1,
    ST_RETRY = 2'd2
  } supState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic clrSticky;
  } ctrlStrobe_t;
endpackage

// File: rtl/uvsup_datapath.sv
module uvsup_datapath
  import uvsup_pkg::*;
#(
  parameter int FAST_CYC  = 50,
  parameter int SLOW_CYC  = 400,
  parameter int SLEEP_MIN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [1:0]  retryMode,
  input  logic        vmGood,
  input  logic        cpGood,
  input  logic        sleepN,
  output logic        retryDone,
  output logic        sleepQual,
  output logic        stsFault,
  output logic        stsUvp,
  output logic        stsVmUv,
  output logic        stsCpUv
);
  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int SLP_W   = $clog2(SLEEP_MIN + 1);

  logic [CNT_W-1:0] retryCnt;
  logic [CNT_W-1:0] limitM1;
  logic [SLP_W-1:0] lowCnt;
  logic             anyBad;

  assign anyBad  = !vmGood || !cpGood;
  assign limitM1 = (retryMode == 2'b00) ? CNT_W'(SLOW_CYC - 1) : CNT_W'(FAST_CYC - 1);
  assign retryDone = (retryCnt >= limitM1);
  assign sleepQual = sleepN && (lowCnt >= SLP_W'(SLEEP_MIN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) retryCnt <= '0;
    else if (strobe.cntClr) retryCnt <= '0;
    else if (strobe.cntInc) retryCnt <= retryCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (sleepN) lowCnt <= '0;
    else if (lowCnt < SLP_W'(SLEEP_MIN)) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsFault <= 1'b0;
      stsUvp   <= 1'b0;
      stsVmUv  <= 1'b0;
      stsCpUv  <= 1'b0;
    end else if (anyBad) begin
      stsFault <= 1'b1;
      stsUvp   <= 1'b1;
      if (!vmGood) stsVmUv <= 1'b1;
      if (!cpGood) stsCpUv <= 1'b1;
    end else if (strobe.clrSticky) begin
      stsFault <= 1'b0;
      stsUvp   <= 1'b0;
      stsVmUv  <= 1'b0;
      stsCpUv  <= 1'b0;
    end
  end

  // R6: the count never runs past the longer window
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < CNT_W'(MAX_CYC));

  // R5: a motor-supply drop latches its status bits
  p_vm_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !vmGood |=> (stsVmUv && stsFault && stsUvp));

  // R10: a clear is ignored while the charge pump is still bad
  p_cp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stsCpUv && !cpGood) |=> stsCpUv);
endmodule

// File: rtl/uvsup_control.sv
module uvsup_control
  import uvsup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vmGood,
  input  logic        cpGood,
  input  logic        faultClr,
  input  logic        sleepQual,
  input  logic        retryDone,
  output ctrlStrobe_t strobe,
  output logic        railRun
);
  supState_t state, nextState;
  logic      anyBad;

  assign anyBad = !vmGood || !cpGood;

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.clrSticky = (faultClr || sleepQual) && !anyBad;
    unique case (state)
      ST_RUN:   if (anyBad) nextState = ST_DOWN;
      ST_DOWN:  if (!anyBad) begin
                  nextState     = ST_RETRY;
                  strobe.cntClr = 1'b1;
                end
      ST_RETRY: if (anyBad) nextState = ST_DOWN;
                else if (retryDone) nextState = ST_RUN;
                else strobe.cntInc = 1'b1;
      default:  nextState = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else state <= nextState;
  end

  assign railRun = (state == ST_RUN);

  // R4: a bad motor or pump rail stops the stage at the next edge
  p_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyBad |=> !railRun);

  // R8: a drop during the count abandons it
  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RETRY && anyBad) |=> (state == ST_DOWN));
endmodule

// File: rtl/uv_supervisor.sv
module uv_supervisor
  import uvsup_pkg::*;
#(
  parameter int FAST_CYC  = 50,
  parameter int SLOW_CYC  = 400,
  parameter int SLEEP_MIN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vmGood,
  input  logic       vinRegGood,
  input  logic       regOutGood,
  input  logic       cpGood,
  input  logic [1:0] retryMode,
  input  logic       faultClr,
  input  logic       sleepN,
  output logic       outEnable,
  output logic       cpEnable,
  output logic       coreReset,
  output logic       faultPinLow,
  output logic       stsFault,
  output logic       stsUvp,
  output logic       stsVmUv,
  output logic       stsCpUv
);
  ctrlStrobe_t strobe;
  logic        retryDone;
  logic        sleepQual;
  logic        railRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreReset <= 1'b1;
    else coreReset <= !(vinRegGood && regOutGood);
  end

  uvsup_control u_ctrl (
    .clk(clk), .rstN(rstN), .vmGood(vmGood), .cpGood(cpGood),
    .faultClr(faultClr), .sleepQual(sleepQual), .retryDone(retryDone),
    .strobe(strobe), .railRun(railRun)
  );

  uvsup_datapath #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .SLEEP_MIN(SLEEP_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retryMode(retryMode),
    .vmGood(vmGood), .cpGood(cpGood), .sleepN(sleepN),
    .retryDone(retryDone), .sleepQual(sleepQual),
    .stsFault(stsFault), .stsUvp(stsUvp), .stsVmUv(stsVmUv), .stsCpUv(stsCpUv)
  );

  assign outEnable   = railRun && !coreReset;
  assign cpEnable    = railRun && !coreReset;
  assign faultPinLow = !railRun;

  // R2: a bad regulator rail forces reset and stops the stage
  p_reg_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(vinRegGood && regOutGood) |=> (coreReset && !outEnable && !cpEnable));

  // R3: reset lets go one edge after both regulator rails are good
  p_reg_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vinRegGood && regOutGood) |=> !coreReset);
endmodule

// File: tb/tb_uv_supervisor.sv
module tb_uv_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int FAST = 50;
  localparam int SLOW = 400;
  localparam int SMIN = 8;

  logic clk = 1'b0;
  logic rstN, vmGood, vinRegGood, regOutGood, cpGood, faultClr, sleepN;
  logic [1:0] retryMode;
  logic outEnable, cpEnable, coreReset, faultPinLow, stsFault, stsUvp, stsVmUv, stsCpUv;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uv_supervisor #(.FAST_CYC(FAST), .SLOW_CYC(SLOW), .SLEEP_MIN(SMIN)) dut (
    .clk(clk), .rstN(rstN), .vmGood(vmGood), .vinRegGood(vinRegGood),
    .regOutGood(regOutGood), .cpGood(cpGood), .retryMode(retryMode),
    .faultClr(faultClr), .sleepN(sleepN), .outEnable(outEnable), .cpEnable(cpEnable),
    .coreReset(coreReset), .faultPinLow(faultPinLow), .stsFault(stsFault),
    .stsUvp(stsUvp), .stsVmUv(stsVmUv), .stsCpUv(stsCpUv)
  );

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stsVec();
    return {stsFault, stsUvp, stsVmUv, stsCpUv};
  endfunction

  task automatic wait_retry(string tag, int lim);
    repeat (lim) @(negedge clk);
    chk({tag, " still off before limit"}, outEnable, 0);
    chk({tag, " pin low before limit"}, faultPinLow, 1);
    @(negedge clk);
    chk({tag, " out back at limit"}, outEnable, 1);
    chk({tag, " pump back at limit"}, cpEnable, 1);
    chk({tag, " pin released"}, faultPinLow, 0);
  endtask

  task automatic clear_sts();
    faultClr = 1'b1; @(negedge clk); faultClr = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; vmGood = 1; vinRegGood = 1; regOutGood = 1; cpGood = 1;
    retryMode = 2'b01; faultClr = 0; sleepN = 1;
    repeat (3) @(negedge clk);
    chk("R2 reset holds core", coreReset, 1);
    chk("R5 status clear in reset", stsVec(), 0);
    rstN = 1'b1; @(negedge clk);
    chk("R3 running after reset", outEnable, 1);
  endtask

  task automatic t_regrail();
    vinRegGood = 0; @(negedge clk);
    chk("R2 core reset", coreReset, 1);
    chk("R2 outputs off", outEnable, 0);
    chk("R2 pump off", cpEnable, 0);
    chk("R3 no pin for reg rail", faultPinLow, 0);
    vinRegGood = 1; regOutGood = 0; repeat (3) @(negedge clk);
    chk("R2 output rail reset", coreReset, 1);
    regOutGood = 1; @(negedge clk);
    chk("R3 immediate release", coreReset, 0);
    chk("R3 outputs back", outEnable, 1);
    chk("R3 no status", stsVec(), 0);
  endtask

  task automatic t_vm_fast();
    retryMode = 2'b01; vmGood = 0; @(negedge clk);
    chk("R4 outputs off", outEnable, 0);
    chk("R4 pump off", cpEnable, 0);
    chk("R4 pin low", faultPinLow, 1);
    chk("R5 vm status", stsVec(), 4'b1110);
    repeat (30) @(negedge clk);
    chk("R6 off while rail bad", outEnable, 0);
    vmGood = 1; wait_retry("R7 fast R6", FAST);
    chk("R9 sticky after recovery", stsVec(), 4'b1110);
    clear_sts(); chk("R9 cleared", stsVec(), 0);
  endtask

  task automatic t_cp_slow();
    retryMode = 2'b00; cpGood = 0; @(negedge clk);
    chk("R5 cp status", stsVec(), 4'b1101);
    cpGood = 1; wait_retry("R7 slow R6", SLOW);
    clear_sts(); chk("R9 cp cleared", stsVec(), 0);
  endtask

  task automatic t_mode11();
    retryMode = 2'b11; vmGood = 0; @(negedge clk);
    chk("R1 mode 11 still stops", outEnable, 0);
    chk("R1 mode 11 still flags", stsVmUv, 1);
    vmGood = 1; wait_retry("R7 mode11 fast", FAST);
    clear_sts();
  endtask

  task automatic t_abort();
    retryMode = 2'b01; vmGood = 0; @(negedge clk);
    vmGood = 1; repeat (30) @(negedge clk);
    cpGood = 0; @(negedge clk);
    chk("R8 stays off on drop", outEnable, 0);
    repeat (40) @(negedge clk);
    chk("R8 no completion while bad", outEnable, 0);
    cpGood = 1; wait_retry("R8 full recount", FAST);
    chk("R5 both rails flagged", stsVec(), 4'b1111);
    clear_sts();
  endtask

  task automatic t_clr_ignored();
    vmGood = 0; @(negedge clk);
    faultClr = 1; @(negedge clk); faultClr = 0;
    @(negedge clk);
    chk("R10 faultClr ignored", stsVec(), 4'b1110);
    sleepN = 0; repeat (SMIN + 2) @(negedge clk); sleepN = 1; @(negedge clk);
    chk("R10 sleep clear ignored", stsVec(), 4'b1110);
    vmGood = 1; wait_retry("R10 recover", FAST);
    chk("R10 still set after recovery", stsVec(), 4'b1110);
  endtask

  task automatic t_sleep();
    sleepN = 0; repeat (SMIN - 2) @(negedge clk); sleepN = 1;
    repeat (2) @(negedge clk);
    chk("R11 short pulse ignored", stsVec(), 4'b1110);
    sleepN = 0; repeat (SMIN) @(negedge clk); sleepN = 1;
    @(negedge clk);
    chk("R11 long pulse clears", stsVec(), 0);
    chk("R11 outputs unaffected", outEnable, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_regrail(); t_vm_fast(); t_cp_slow(); t_mode11();
        t_abort(); t_clr_ignored(); t_sleep();
        finished = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          nRun++; nFail++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule